// File: doc/BRIEF.md
# Load Miss Fold Queue

This block parks loads whose line address has already matched an outstanding miss entry in the reload buffer. Such a load does not start a second miss. It takes one of four queue slots, and the cache access path is free again in the next cycle for other loads and stores. Each slot records which reload-buffer entry it depends on, the byte range it needs, the load size and a destination tag. It waits only on those bytes, not on the whole line fill.

The reload buffer presents, for every entry, a byte-valid mask, the line data and a flag that marks entries allocated by caching-inhibited accesses. Every cycle, each parked load compares its required-byte mask with the valid mask of its entry. Among the loads that are ready, the one allocated earliest is granted. Its bytes are pulled out of the line, right-justified, and driven on a registered result bus with its tag. Fold requests that target an inhibited entry are rejected. Requests that arrive while all slots are busy are refused, and the requester retries them.

Top module: `lmfq_top`

## Requirements
- R1: After a synchronous reset the queue is empty: `q_full` and `res_valid` are low, and no result appears until a request has been accepted.
- R2: A request with `fold_valid` high, `q_full` low and the inhibit flag of the target entry low is accepted in the same cycle (`fold_accept` high). The load is stored at that clock edge. If all of its needed bytes are valid during the following cycle, `res_valid` is high in the cycle after the next edge. Each stored load produces exactly one result.
- R3: `fold_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Offset bits below the size are ignored, which aligns the access naturally. The load waits until every byte in [aligned offset, aligned offset + size) of its entry is valid. Validity of other bytes in the line has no effect.
- R4: `res_data[7:0]` carries the byte at the aligned offset, and the following bytes fill upward. Bits above the load size are zero. `res_dtag` equals the tag given with the request.
- R5: A request to an entry whose `rlb_inhibit` bit is set drives `fold_reject` high and `fold_accept` low in that cycle. Nothing is stored, so no result with its tag ever appears.
- R6: At most one result is driven per cycle. When several parked loads are ready in the same cycle, the one accepted earliest is issued first, whatever slot it occupies.
- R7: `q_full` is high while four loads are parked. A request seen while `q_full` is high gets `fold_accept` low and is dropped. `q_full` falls after an edge at which a load issues.
- R8: When one load issues at an edge and a new request is accepted at the same edge, both take effect: the old result is driven and the new load is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fold_valid | input | 1 | Fold request present |
| fold_rlb_idx | input | 3 | Reload-buffer entry the load matched |
| fold_offset | input | 5 | Byte offset of the load within the 32-byte line |
| fold_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| fold_dtag | input | 6 | Destination tag of the load |
| rlb_inhibit | input | 8 | Per entry: allocated by a caching-inhibited access |
| rlb_byte_valid | input | 256 | Per entry byte-valid masks, entry e at bits [e*32 +: 32] |
| rlb_line_data | input | 2048 | Per entry line data, entry e at bits [e*256 +: 256], byte b at [b*8 +: 8] |
| fold_accept | output | 1 | Request accepted this cycle |
| fold_reject | output | 1 | Request refused because its entry is caching-inhibited |
| q_full | output | 1 | All four slots occupied |
| res_valid | output | 1 | Result bus valid |
| res_data | output | 64 | Right-justified load data |
| res_dtag | output | 6 | Destination tag of the result |

## Verification
Issue of a parked load and acceptance of a new fold can land on the same clock edge. The bench provokes this by making the bytes of a waiting entry valid in the same cycle that it presents a new request to an already-filled line. It then expects the old load's result after that edge and the new load's result one edge later, each with its own tag and data. A second collision comes from making two loads on different lines ready together after the younger one reused the lower slot. In that case the older load must come out first.

// File: rtl/lmfq_pkg.sv
package lmfq_pkg;

  typedef enum logic [1:0] {
    LD_B1 = 2'd0,
    LD_B2 = 2'd1,
    LD_B4 = 2'd2,
    LD_B8 = 2'd3
  } ld_size_e;

  function automatic int unsigned size_bytes(ld_size_e s);
    return 32'd1 << s;
  endfunction

endpackage

// File: rtl/lmfq_need_mask.sv
module lmfq_need_mask
  import lmfq_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic [OFF_W-1:0]      offset,
  input  ld_size_e              size,
  output logic [OFF_W-1:0]      base,
  output logic [LINE_BYTES-1:0] need
);

  int unsigned nb;

  always_comb begin
    nb   = size_bytes(size);
    base = offset & ~OFF_W'(nb - 1);
    for (int b = 0; b < LINE_BYTES; b++) begin
      need[b] = (b >= int'(base)) && (b < int'(base) + int'(nb));
    end
  end

endmodule

// File: rtl/lmfq_byte_sel.sv
module lmfq_byte_sel
  import lmfq_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int RES_BYTES  = 8,
  parameter int OFF_W      = $clog2(LINE_BYTES)
) (
  input  logic [LINE_BYTES*8-1:0] line,
  input  logic [OFF_W-1:0]        base,
  input  ld_size_e                size,
  output logic [RES_BYTES*8-1:0]  data
);

  logic [LINE_BYTES*8-1:0] shifted;
  int unsigned             nb;

  always_comb begin
    shifted = line >> (int'(base) * 8);
    nb      = size_bytes(size);
    for (int b = 0; b < RES_BYTES; b++) begin
      data[b*8 +: 8] = (b < int'(nb)) ? shifted[b*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/lmfq_age_pick.sv
module lmfq_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc_vec,
  input  logic [N-1:0] valid,
  input  logic [N-1:0] ready,
  output logic [N-1:0] grant
);

  // older_q[j][i] set: slot j was allocated before slot i
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_vec[i]) begin
          for (int j = 0; j < N; j++) begin
            older_q[i][j] <= 1'b0;
            if (j != i) older_q[j][i] <= valid[j];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (ready[j] && older_q[j][i]) blocked = 1'b1;
      end
      grant[i] = ready[i] && !blocked;
    end
  end

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_ord_i
      for (genvar gj = 0; gj < N; gj++) begin : g_ord_j
        if (gi < gj) begin : g_pair
          AST_AGE_ANTISYM: assert property (@(posedge clk) disable iff (rst)
            (valid[gi] && valid[gj]) |-> !(older_q[gi][gj] && older_q[gj][gi])); // R6
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lmfq_top.sv
module lmfq_top
  import lmfq_pkg::*;
#(
  parameter int Q_DEPTH    = 4,
  parameter int RLB_N      = 8,
  parameter int LINE_BYTES = 32,
  parameter int RES_BYTES  = 8,
  parameter int DTAG_W     = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fold_valid,
  input  logic [$clog2(RLB_N)-1:0]      fold_rlb_idx,
  input  logic [$clog2(LINE_BYTES)-1:0] fold_offset,
  input  logic [1:0]                    fold_size,
  input  logic [DTAG_W-1:0]             fold_dtag,
  input  logic [RLB_N-1:0]              rlb_inhibit,
  input  logic [RLB_N*LINE_BYTES-1:0]   rlb_byte_valid,
  input  logic [RLB_N*LINE_BYTES*8-1:0] rlb_line_data,
  output logic                          fold_accept,
  output logic                          fold_reject,
  output logic                          q_full,
  output logic                          res_valid,
  output logic [RES_BYTES*8-1:0]        res_data,
  output logic [DTAG_W-1:0]             res_dtag
);

  localparam int IDX_W  = $clog2(RLB_N);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SLOT_W = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int LINE_W = LINE_BYTES * 8;

  // slot storage
  logic [Q_DEPTH-1:0]    q_valid;
  logic [IDX_W-1:0]      q_idx  [Q_DEPTH];
  logic [OFF_W-1:0]      q_base [Q_DEPTH];
  ld_size_e              q_size [Q_DEPTH];
  logic [LINE_BYTES-1:0] q_need [Q_DEPTH];
  logic [DTAG_W-1:0]     q_tag  [Q_DEPTH];

  // request decode
  ld_size_e              req_size;
  logic [OFF_W-1:0]      req_base;
  logic [LINE_BYTES-1:0] req_need;

  assign req_size = ld_size_e'(fold_size);

  lmfq_need_mask #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W)) u_need (
    .offset (fold_offset),
    .size   (req_size),
    .base   (req_base),
    .need   (req_need)
  );

  assign q_full      = &q_valid;
  assign fold_reject = fold_valid && rlb_inhibit[fold_rlb_idx];
  assign fold_accept = fold_valid && !q_full && !rlb_inhibit[fold_rlb_idx];

  // lowest free slot
  logic [SLOT_W-1:0]  free_slot;
  logic [Q_DEPTH-1:0] alloc_vec;

  always_comb begin
    free_slot = '0;
    for (int i = Q_DEPTH - 1; i >= 0; i--) begin
      if (!q_valid[i]) free_slot = SLOT_W'(i);
    end
    alloc_vec = '0;
    if (fold_accept) alloc_vec[free_slot] = 1'b1;
  end

  // readiness per slot
  logic [Q_DEPTH-1:0] ready;

  generate
    for (genvar g = 0; g < Q_DEPTH; g++) begin : g_ready
      logic [LINE_BYTES-1:0] line_bv;
      assign line_bv  = rlb_byte_valid[int'(q_idx[g])*LINE_BYTES +: LINE_BYTES];
      assign ready[g] = q_valid[g] && ((q_need[g] & ~line_bv) == '0);
    end
  endgenerate

  // age-ordered pick
  logic [Q_DEPTH-1:0] grant;
  logic               issue;
  logic [SLOT_W-1:0]  gslot;

  lmfq_age_pick #(.N(Q_DEPTH)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .alloc_vec (alloc_vec),
    .valid     (q_valid),
    .ready     (ready),
    .grant     (grant)
  );

  always_comb begin
    gslot = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (grant[i]) gslot = SLOT_W'(i);
    end
  end

  assign issue = |grant;

  // data extraction for the granted slot
  logic [LINE_W-1:0]      sel_line;
  logic [RES_BYTES*8-1:0] sel_data;

  assign sel_line = rlb_line_data[int'(q_idx[gslot])*LINE_W +: LINE_W];

  lmfq_byte_sel #(.LINE_BYTES(LINE_BYTES), .RES_BYTES(RES_BYTES), .OFF_W(OFF_W)) u_sel (
    .line (sel_line),
    .base (q_base[gslot]),
    .size (q_size[gslot]),
    .data (sel_data)
  );

  // slot state
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= '0;
    end else begin
      for (int i = 0; i < Q_DEPTH; i++) begin
        if (alloc_vec[i])  q_valid[i] <= 1'b1;
        else if (grant[i]) q_valid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (alloc_vec[i]) begin
        q_idx[i]  <= fold_rlb_idx;
        q_base[i] <= req_base;
        q_size[i] <= req_size;
        q_need[i] <= req_need;
        q_tag[i]  <= fold_dtag;
      end
    end
  end

  // registered result bus
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_dtag  <= '0;
    end else begin
      res_valid <= issue;
      if (issue) begin
        res_data <= sel_data;
        res_dtag <= q_tag[gslot];
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R6

  AST_GRANT_READY: assert property (@(posedge clk) disable iff (rst)
    ((grant & ~ready) == '0)); // R3

  AST_RESULT_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue |=> res_valid); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (fold_accept && !issue) |=> ($countones(q_valid) == $past($countones(q_valid)) + 1)); // R7

  AST_REJECT_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (fold_valid && rlb_inhibit[fold_rlb_idx] && !issue) |=>
      ($countones(q_valid) == $past($countones(q_valid)))); // R5

endmodule

// File: tb/sim_lmfq_top.sv
`timescale 1ns/1ps
module sim_lmfq_top;

  localparam int QD = 4;
  localparam int RN = 8;
  localparam int LB = 32;
  localparam int RB = 8;
  localparam int TW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fold_valid = 1'b0;
  logic [2:0]        fold_rlb_idx = '0;
  logic [4:0]        fold_offset = '0;
  logic [1:0]        fold_size = '0;
  logic [TW-1:0]     fold_dtag = '0;
  logic [RN-1:0]     inh = '0;
  logic [RN*LB-1:0]  bv = '0;
  logic [RN*LB*8-1:0] ld = '0;
  logic              fold_accept, fold_reject, q_full, res_valid;
  logic [RB*8-1:0]   res_data;
  logic [TW-1:0]     res_dtag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  lmfq_top #(.Q_DEPTH(QD), .RLB_N(RN), .LINE_BYTES(LB), .RES_BYTES(RB), .DTAG_W(TW)) u0 (
    .clk(clk), .rst(rst), .fold_valid(fold_valid), .fold_rlb_idx(fold_rlb_idx),
    .fold_offset(fold_offset), .fold_size(fold_size), .fold_dtag(fold_dtag),
    .rlb_inhibit(inh), .rlb_byte_valid(bv), .rlb_line_data(ld),
    .fold_accept(fold_accept), .fold_reject(fold_reject), .q_full(q_full),
    .res_valid(res_valid), .res_data(res_data), .res_dtag(res_dtag)
  );

  function automatic logic [7:0] pat(int e, int b);
    return 8'(e * 37 + b * 5 + 1);
  endfunction

  function automatic logic [63:0] exp_data(int e, int off, int sz);
    logic [63:0] r;
    int nb, a;
    r  = '0;
    nb = 1 << sz;
    a  = off & ~(nb - 1);
    for (int k = 0; k < nb; k++) r[k*8 +: 8] = pat(e, a + k);
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_line(int e, logic [31:0] m);
    bv[e*LB +: LB] = m;
  endtask

  task automatic expect_res(string req, int tag, logic [63:0] d);
    chk(res_valid == 1'b1, req, "res_valid", 64'(res_valid), 64'd1);
    chk(res_dtag == TW'(tag), req, "res_dtag", 64'(res_dtag), 64'(tag));
    chk(res_data == d, req, "res_data", res_data, d);
  endtask

  task automatic expect_idle(string req);
    chk(res_valid == 1'b0, req, "res_valid idle", 64'(res_valid), 64'd0);
  endtask

  task automatic fold(int idx, int off, int sz, int tag, bit exp_acc, string req);
    fold_valid   = 1'b1;
    fold_rlb_idx = 3'(idx);
    fold_offset  = 5'(off);
    fold_size    = 2'(sz);
    fold_dtag    = TW'(tag);
    #1;
    chk(fold_accept == exp_acc, req, "fold_accept", 64'(fold_accept), 64'(exp_acc));
    step();
    fold_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(q_full == 1'b0, "R1", "q_full after reset", 64'(q_full), 64'd0);
    expect_idle("R1");
    chk(fold_accept == 1'b0, "R1", "fold_accept idle", 64'(fold_accept), 64'd0);
    step();
    expect_idle("R1");
  endtask

  task automatic t_immediate();
    set_line(2, 32'hFFFF_FFFF);
    fold(2, 8, 3, 5, 1'b1, "R2");
    expect_idle("R2");
    step();
    expect_res("R4", 5, exp_data(2, 8, 3));
    step();
    expect_idle("R2");
  endtask

  task automatic t_partial();
    set_line(3, 32'hFFFF_FFCF);
    fold(3, 5, 1, 7, 1'b1, "R3");
    for (int i = 0; i < 3; i++) begin
      step();
      expect_idle("R3");
    end
    set_line(3, 32'hFFFF_FFDF);
    step();
    expect_idle("R3");
    set_line(3, 32'hFFFF_FFFF);
    step();
    expect_res("R3", 7, exp_data(3, 4, 1));
    step();
    expect_idle("R3");
  endtask

  task automatic t_sizes();
    set_line(4, 32'h00F0_0000);
    fold(4, 22, 2, 9, 1'b1, "R3");
    step();
    expect_res("R4", 9, exp_data(4, 20, 2));
    set_line(5, 32'h8000_0000);
    fold(5, 31, 0, 10, 1'b1, "R3");
    step();
    expect_res("R4", 10, exp_data(5, 31, 0));
    step();
    expect_idle("R4");
  endtask

  task automatic t_inhibit();
    inh[6] = 1'b1;
    set_line(6, 32'hFFFF_FFFF);
    fold_valid   = 1'b1;
    fold_rlb_idx = 3'd6;
    fold_offset  = 5'd0;
    fold_size    = 2'd2;
    fold_dtag    = TW'(33);
    #1;
    chk(fold_accept == 1'b0, "R5", "fold_accept", 64'(fold_accept), 64'd0);
    chk(fold_reject == 1'b1, "R5", "fold_reject", 64'(fold_reject), 64'd1);
    step();
    fold_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      expect_idle("R5");
    end
    chk(q_full == 1'b0, "R5", "q_full", 64'(q_full), 64'd0);
    inh[6] = 1'b0;
  endtask

  task automatic t_full();
    set_line(0, 32'h0);
    set_line(1, 32'h0);
    set_line(7, 32'hFFFF_FFFF);
    fold(0, 0, 3, 1, 1'b1, "R7");
    fold(1, 8, 2, 2, 1'b1, "R7");
    fold(0, 16, 1, 3, 1'b1, "R7");
    chk(q_full == 1'b0, "R7", "q_full at three", 64'(q_full), 64'd0);
    fold(1, 4, 0, 4, 1'b1, "R7");
    chk(q_full == 1'b1, "R7", "q_full at four", 64'(q_full), 64'd1);
    fold(7, 0, 3, 9, 1'b0, "R7");
    expect_idle("R7");
    set_line(1, 32'hFFFF_FFFF);
    step();
    expect_res("R6", 2, exp_data(1, 8, 2));
    chk(q_full == 1'b0, "R7", "q_full after issue", 64'(q_full), 64'd0);
    step();
    expect_res("R6", 4, exp_data(1, 4, 0));
    step();
    expect_idle("R7");
    set_line(0, 32'hFFFF_FFFF);
    step();
    expect_res("R6", 1, exp_data(0, 0, 3));
    step();
    expect_res("R6", 3, exp_data(0, 16, 1));
    step();
    expect_idle("R7");
  endtask

  task automatic t_age();
    set_line(0, 32'h0);
    set_line(1, 32'h0);
    fold(0, 0, 0, 11, 1'b1, "R6");
    fold(1, 0, 0, 12, 1'b1, "R6");
    set_line(0, 32'h0000_0001);
    step();
    expect_res("R6", 11, exp_data(0, 0, 0));
    set_line(0, 32'h0);
    fold(0, 2, 0, 13, 1'b1, "R6");
    expect_idle("R6");
    set_line(0, 32'hFFFF_FFFF);
    set_line(1, 32'hFFFF_FFFF);
    step();
    expect_res("R6", 12, exp_data(1, 0, 0));
    step();
    expect_res("R6", 13, exp_data(0, 2, 0));
    step();
    expect_idle("R6");
  endtask

  task automatic t_concurrent();
    set_line(1, 32'h0);
    set_line(2, 32'hFFFF_FFFF);
    fold(1, 16, 3, 20, 1'b1, "R8");
    expect_idle("R8");
    set_line(1, 32'hFFFF_FFFF);
    fold(2, 0, 2, 21, 1'b1, "R8");
    expect_res("R8", 20, exp_data(1, 16, 3));
    step();
    expect_res("R8", 21, exp_data(2, 0, 2));
    step();
    expect_idle("R8");
  endtask

  initial begin
    for (int e = 0; e < RN; e++)
      for (int b = 0; b < LB; b++)
        ld[(e*LB + b)*8 +: 8] = pat(e, b);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_partial();
    t_sizes();
    t_inhibit();
    t_full();
    t_age();
    t_concurrent();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule